// File: doc/BRIEF.md
# Cache Line Refill Sequencer with Early Processor Restart

This block fills one cache line from memory after a miss and releases the waiting processor as soon as the word it needs has arrived. It does not wait for the rest of the line. A miss is handed over with a line address, the offset of the missed word and a fill mode. The block then issues one word request per accepted handshake on its memory request channel. It takes the returned words in request order and writes each one into the line storage through a write port. The block has two fill modes. In wrap mode the missed word is fetched first and the other words follow in ascending order, wrapping around the end of the line. In linear mode the words are fetched from word 0 upwards, and the missed word is forwarded when its turn comes.

The miss input, the memory request channel and the memory response channel use valid/ready handshakes. A transfer happens only on a clock edge where both valid and ready are high. A valid request must be held, with a stable address, until it is taken. The memory may insert any number of idle cycles between responses. The processor restart output, the line-buffer write port, the completion pulse and the presence probe are plain signals. A presence probe tells the cache whether a given word of the filling line has already been written. A processor access to a word that has not arrived yet must stall until the probe reports it present.

Top module: `refill_ctrl`

## Requirements
- R1: `miss_ready` is high only while no fill is in progress. A miss presented while a fill runs is neither accepted nor allowed to change the line being filled.
- R2: In wrap mode (`miss_cwf`=1) the k-th request (k = 0..7) carries the word address {line, (offset + k) mod 8}, where the low 3 bits are the word index. Exactly 8 requests are issued per fill.
- R3: In linear mode (`miss_cwf`=0) the k-th request carries the word address {line, k}.
- R4: Every accepted response is written through the line-buffer port in the same cycle (`lb_we`=1). `lb_idx` is the index of the word requested in the same position, and `lb_data` is the response data. No cycle without an accepted response writes.
- R5: `cpu_restart` pulses exactly once per fill, in the cycle of the response that carries the missed word. In that cycle `cpu_data` equals the response data.
- R6: After the restart, the remaining words keep being written. This is 7 further writes in wrap mode and 7 − offset further writes in linear mode.
- R7: `line_done` is high for exactly one cycle, the cycle after the eighth write. `miss_ready` rises in the following cycle.
- R8: `chk_present` is 1 for word `chk_word` exactly when that word was written by the current or the most recently completed fill. It is 0 after reset and after a new miss is accepted.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address are held in the next cycle.
- R10: Out of reset, `miss_ready`=1 and `mem_req_valid`, `lb_we`, `cpu_restart` and `line_done` are all 0.
- R11: `mem_rsp_ready` is high during a fill whenever at least one requested word has not yet been returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Ready to accept a miss |
| miss_line | input | 26 | Line address of the miss |
| miss_word | input | 3 | Offset of the missed word in the line |
| miss_cwf | input | 1 | 1 = wrap mode (missed word first), 0 = linear mode |
| mem_req_valid | output | 1 | Word request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 29 | Word address {line, index} |
| mem_rsp_valid | input | 1 | Returned word valid |
| mem_rsp_ready | output | 1 | Block takes the returned word |
| mem_rsp_data | input | 32 | Returned word |
| cpu_restart | output | 1 | Missed word delivered, processor may resume |
| cpu_data | output | 32 | Missed word data, valid with `cpu_restart` |
| lb_we | output | 1 | Line-buffer write enable |
| lb_idx | output | 3 | Word index written |
| lb_data | output | 32 | Word data written |
| line_done | output | 1 | Whole line written (one-cycle pulse) |
| chk_word | input | 3 | Word index probed |
| chk_present | output | 1 | Probed word already written |

## Verification
The assertions take it for granted that memory answers only words it has been asked for and answers them in request order. This means `mem_rsp_valid` is never raised unless a requested word is still outstanding. The bench's memory model keeps a queue of the addresses it has accepted. It raises a response only when that queue is non-empty, and it always answers from the head of the queue. Stalls on both the request and the response side are produced by periodic ready and valid gaps, so the ordering assumption still holds.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } refill_state_e;
endpackage

// File: rtl/refill_seq.sv
// Position counter and word-index generator for one side of the refill.
module refill_seq #(
  parameter int WORDS = 8,
  localparam int OW = $clog2(WORDS),
  localparam int CW = OW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [OW-1:0] start,
  input  logic          wrap_mode,
  output logic [OW-1:0] idx,
  output logic [CW-1:0] count,
  output logic          all_done
);
  localparam logic [CW-1:0] END_CNT = CW'(WORDS);

  logic [OW:0] sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (step)   count <= count + 1'b1;
  end

  assign all_done = (count == END_CNT);
  assign sum      = {1'b0, start} + {1'b0, count[OW-1:0]};

  generate
    if ((1 << OW) == WORDS) begin : g_pow2
      assign idx = wrap_mode ? sum[OW-1:0] : count[OW-1:0];
    end else begin : g_modulo
      localparam logic [OW:0] WRAP_AT = (OW + 1)'(WORDS);
      logic [OW:0] wrapped;
      assign wrapped = (sum >= WRAP_AT) ? (sum - WRAP_AT) : sum;
      assign idx = wrap_mode ? wrapped[OW-1:0] : count[OW-1:0];
    end
  endgenerate

  // R2: a line never receives more than WORDS steps on either side
  a_r2_no_overstep: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !all_done);
endmodule

// File: rtl/refill_track.sv
// Record of which words of the line have been written.
module refill_track #(
  parameter int WORDS = 8,
  localparam int OW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          we,
  input  logic [OW-1:0] widx,
  input  logic [OW-1:0] probe,
  output logic          present,
  output logic          full
);
  logic [WORDS-1:0] filled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      filled <= '0;
    else if (clear)  filled <= '0;
    else if (we)     filled[widx] <= 1'b1;
  end

  assign present = filled[probe];
  assign full    = &filled;

  // R4: each word of a line is written once only
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !filled[widx]);
endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int WORDS   = 8,
  parameter int LINE_AW = 26,
  parameter int DW      = 32,
  localparam int OW = $clog2(WORDS),
  localparam int CW = OW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  output logic               miss_ready,
  input  logic [LINE_AW-1:0] miss_line,
  input  logic [OW-1:0]      miss_word,
  input  logic               miss_cwf,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [LINE_AW+OW-1:0] mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [DW-1:0]      mem_rsp_data,
  output logic               cpu_restart,
  output logic [DW-1:0]      cpu_data,
  output logic               lb_we,
  output logic [OW-1:0]      lb_idx,
  output logic [DW-1:0]      lb_data,
  output logic               line_done,
  input  logic [OW-1:0]      chk_word,
  output logic               chk_present
);
  refill_state_e      state;
  logic [LINE_AW-1:0] line_q;
  logic [OW-1:0]      word_q;
  logic               cwf_q;
  logic               restart_seen;

  logic          accept, req_fire, rsp_fire, filling;
  logic [OW-1:0] req_idx, rsp_idx;
  logic [CW-1:0] req_count, rsp_count;
  logic          req_all, rsp_all, line_full;

  assign filling  = (state == ST_FILL);
  assign miss_ready = !filling;
  assign accept   = miss_valid && miss_ready;
  assign req_fire = mem_req_valid && mem_req_ready;
  assign rsp_fire = mem_rsp_valid && mem_rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      line_q <= '0;
      word_q <= '0;
      cwf_q  <= 1'b0;
    end else if (accept) begin
      state  <= ST_FILL;
      line_q <= miss_line;
      word_q <= miss_word;
      cwf_q  <= miss_cwf;
    end else if (filling && rsp_all) begin
      state  <= ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           restart_seen <= 1'b0;
    else if (accept)      restart_seen <= 1'b0;
    else if (cpu_restart) restart_seen <= 1'b1;
  end

  refill_seq #(.WORDS(WORDS)) i_req_seq (
    .clk, .rst_n,
    .clear     (accept),
    .step      (req_fire),
    .start     (word_q),
    .wrap_mode (cwf_q),
    .idx       (req_idx),
    .count     (req_count),
    .all_done  (req_all)
  );

  refill_seq #(.WORDS(WORDS)) i_rsp_seq (
    .clk, .rst_n,
    .clear     (accept),
    .step      (rsp_fire),
    .start     (word_q),
    .wrap_mode (cwf_q),
    .idx       (rsp_idx),
    .count     (rsp_count),
    .all_done  (rsp_all)
  );

  refill_track #(.WORDS(WORDS)) i_track (
    .clk, .rst_n,
    .clear   (accept),
    .we      (lb_we),
    .widx    (lb_idx),
    .probe   (chk_word),
    .present (chk_present),
    .full    (line_full)
  );

  assign mem_req_valid = filling && !req_all;
  assign mem_req_addr  = {line_q, req_idx};
  assign mem_rsp_ready = filling && (req_count != rsp_count);

  assign lb_we       = rsp_fire;
  assign lb_idx      = rsp_idx;
  assign lb_data     = mem_rsp_data;
  assign cpu_restart = rsp_fire && (rsp_idx == word_q);
  assign cpu_data    = mem_rsp_data;
  assign line_done   = filling && rsp_all;

  // R5: one restart per fill
  a_r5_single_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_restart |-> !restart_seen);
  // R5: by completion the processor has been released
  a_r5_restart_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> restart_seen);
  // R7: completion only once every word is written
  a_r7_done_means_full: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> line_full);
  // R9: a stalled request is held unchanged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R4: memory only returns words that were asked for (input assumption)
  a_r4_rsp_requested: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> mem_rsp_ready);
endmodule

// File: tb/test_refill_ctrl.sv
module test_refill_ctrl;
  localparam int WORDS = 8;
  localparam int LAW   = 26;
  localparam int DW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0, miss_ready;
  logic [LAW-1:0] miss_line = '0;
  logic [2:0] miss_word = '0;
  logic miss_cwf = 1'b0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [LAW+2:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [DW-1:0] mem_rsp_data = '0;
  logic cpu_restart;
  logic [DW-1:0] cpu_data;
  logic lb_we;
  logic [2:0] lb_idx;
  logic [DW-1:0] lb_data;
  logic line_done;
  logic [2:0] chk_word = '0;
  logic chk_present;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  refill_ctrl #(.WORDS(WORDS), .LINE_AW(LAW), .DW(DW)) i_refill_ctrl (
    .clk, .rst_n, .miss_valid, .miss_ready, .miss_line, .miss_word, .miss_cwf,
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
    .cpu_restart, .cpu_data, .lb_we, .lb_idx, .lb_data, .line_done,
    .chk_word, .chk_present
  );

  function automatic logic [DW-1:0] mdata(input logic [LAW+2:0] a);
    return {a, 3'b101} ^ 32'h6B1D_4E93;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 miss_ready", 64'(miss_ready), 64'd1);
    check("R10 mem_req_valid", 64'(mem_req_valid), 64'd0);
    check("R10 lb_we", 64'(lb_we), 64'd0);
    check("R10 cpu_restart", 64'(cpu_restart), 64'd0);
    check("R10 line_done", 64'(line_done), 64'd0);
    check("R8 probe after reset", 64'(chk_present), 64'd0);
  endtask

  task automatic run_fill(input logic [LAW-1:0] line, input logic [2:0] w, input bit cwf,
                          input int req_gap, input int rsp_gap, input bit poke);
    logic [LAW+2:0] fifo [0:WORDS-1];
    bit seen [0:WORDS-1];
    int wp = 0, rp = 0, nreq = 0, nwr = 0, restarts = 0, after = 0;
    bit hold = 0;
    logic [LAW+2:0] held_addr = '0;
    logic [LAW+2:0] exp_addr;
    logic [2:0] kidx;
    bit exp_rs;
    for (int i = 0; i < WORDS; i++) seen[i] = 0;
    @(negedge clk);
    miss_valid = 1'b1; miss_line = line; miss_word = w; miss_cwf = cwf;
    #1 check("R1 ready when idle", 64'(miss_ready), 64'd1);
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      miss_valid = poke;
      if (poke) begin miss_line = ~line; miss_word = w + 3'd3; miss_cwf = ~cwf; end
      mem_req_ready = (req_gap == 0) || (cyc % (req_gap + 1) == 0);
      if (rp < wp && (rsp_gap == 0 || cyc % (rsp_gap + 1) == 1)) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = mdata(fifo[rp]);
      end else begin
        mem_rsp_valid = 1'b0;
      end
      chk_word = 3'(cyc);
      #1;
      check("R1 not ready while filling", 64'(miss_ready), 64'd0);
      check("R8 probe", 64'(chk_present), 64'(seen[chk_word]));
      if (rp < wp) check("R11 rsp_ready", 64'(mem_rsp_ready), 64'd1);
      if (hold) begin
        check("R9 held valid", 64'(mem_req_valid), 64'd1);
        check("R9 held addr", 64'(mem_req_addr), 64'(held_addr));
      end
      if (nreq == WORDS) check("R2 no extra request", 64'(mem_req_valid), 64'd0);
      if (mem_req_valid && nreq < WORDS) begin
        kidx = cwf ? 3'(w + 3'(nreq)) : 3'(nreq);
        exp_addr = {line, kidx};
        if (cwf) check("R2 wrap order", 64'(mem_req_addr), 64'(exp_addr));
        else     check("R3 linear order", 64'(mem_req_addr), 64'(exp_addr));
        if (mem_req_ready) begin fifo[wp] = mem_req_addr; wp++; nreq++; end
      end
      hold = mem_req_valid && !mem_req_ready;
      held_addr = mem_req_addr;
      if (mem_rsp_valid) begin
        exp_rs = (fifo[rp][2:0] == w);
        check("R4 lb_we", 64'(lb_we), 64'd1);
        check("R4 lb_idx", 64'(lb_idx), 64'(fifo[rp][2:0]));
        check("R4 lb_data", 64'(lb_data), 64'(mdata(fifo[rp])));
        check("R5 restart", 64'(cpu_restart), 64'(exp_rs));
        if (exp_rs) check("R5 cpu_data", 64'(cpu_data), 64'(mdata(fifo[rp])));
        if (restarts > 0) after++;
        if (cpu_restart) restarts++;
        seen[fifo[rp][2:0]] = 1;
        rp++; nwr++;
      end else begin
        check("R4 no write", 64'(lb_we), 64'd0);
        check("R5 no restart", 64'(cpu_restart), 64'd0);
      end
      if (nwr == WORDS) break;
    end
    @(negedge clk);
    miss_valid = 1'b0; mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
    #1;
    check("R7 done pulse", 64'(line_done), 64'd1);
    check("R7 still busy", 64'(miss_ready), 64'd0);
    check("R5 one restart", 64'(restarts), 64'd1);
    check("R6 writes after restart", 64'(after), cwf ? 64'd7 : 64'(7 - int'(w)));
    @(negedge clk);
    #1;
    check("R7 done ends", 64'(line_done), 64'd0);
    check("R7 ready again", 64'(miss_ready), 64'd1);
    chk_word = 3'(w + 3'd1);
    #1 check("R8 probe after fill", 64'(chk_present), 64'd1);
  endtask

  task automatic t_cwf_fast;     run_fill(26'h12_3456, 3'd5, 1'b1, 0, 0, 1'b0); endtask
  task automatic t_linear_gaps;  run_fill(26'h0A_BCDE, 3'd3, 1'b0, 0, 2, 1'b0); endtask
  task automatic t_cwf_word0;    run_fill(26'h3F_0001, 3'd0, 1'b1, 1, 1, 1'b0); endtask
  task automatic t_linear_last;  run_fill(26'h00_7777, 3'd7, 1'b0, 0, 0, 1'b0); endtask
  task automatic t_cwf_backpres; run_fill(26'h2A_AAAA, 3'd7, 1'b1, 3, 0, 1'b0); endtask
  task automatic t_busy_miss;    run_fill(26'h15_5555, 3'd2, 1'b1, 1, 1, 1'b1); endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cwf_fast();
    t_linear_gaps();
    t_cwf_word0();
    t_linear_last();
    t_cwf_backpres();
    t_busy_miss();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule